// File: doc/BRIEF.md
# Multi-channel PWM source generator

This block produces the switching enables for eleven output drivers. Each channel takes its on/off pattern from one of two external PWM pins or from an internal duty-cycle generator. The channel's enable bit then gates that pattern. Four internal generators are built in. Each one pairs a free-running 7-bit counter with a 7-bit duty value. A per-generator select bit clocks the counter at one of two rates, and those rates come from a shared prescaler that divides the system clock.

A single global mode bit decides whether channels 7 to 10 are driven by the internal generators or by the external pins. The channel-to-source map is fixed. All settings are loaded through a plain parallel write port. Every channel output is registered.

Top module: `pwm_src_gen`

## Requirements
- R1: With mode set, a generator with duty D (field bits [6:0] at address 4+g) drives its channel high while its counter is below D. Over one 128-count period the output is high for exactly D counts: D=0 holds it low, and D=127 gives 127 high counts out of 128.
- R2: Frequency-select bit g at address 2 (bits [3:0]) picks the count rate of generator g. A value of 0 counts once every DIV1 clocks (f1), and a value of 1 counts once every DIV2 clocks (f2). A period therefore lasts 128*DIV1 or 128*DIV2 clocks.
- R3: When the mode bit (address 0, bit 0) is 0, channels 5, 8 and 10 follow pin pwm2_i. All other channels follow pin pwm1_i.
- R4: When the mode bit is 1, channels 7, 8, 9 and 10 follow generators 0, 1, 2 and 3 in that order.
- R5: In both modes, channel 5 follows pwm2_i, and channels 1 to 4, 6 and 11 follow pwm1_i.
- R6: The enable register at address 1 has one bit per channel, bit i for channel i+1. Channel output out_en_o[i] is the selected source ANDed with that bit, so a cleared bit holds the output low whatever its source does.
- R7: A newly written duty value is applied only when the generator's counter wraps from 127 to 0. A write in mid-period leaves the rest of the running period unchanged.
- R8: A synchronous reset clears the mode bit, all enables, all frequency selects and all duty values, which drives every output low.
- R9: Outputs are registered. A pin change sampled at one clock edge appears on out_en_o after the next edge. A register write takes effect on the output one clock later than a pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address: 0 mode, 1 enables, 2 frequency selects, 4..7 duties |
| wr_data_i | input | 16 | Register write data |
| pwm1_i | input | 1 | External PWM source 1 |
| pwm2_i | input | 1 | External PWM source 2 |
| out_en_o | output | 11 | Per-channel output enable, bit i is channel i+1 |

## Verification
The bench drives the routing table in both modes with every pin combination.

- A design that swaps a channel's source, or moves channel 5 into the generator set, shows a wrong output pattern.
- Generators are measured by counting high cycles over a whole period, so an off-by-one compare gives 0 or 127 counts wrong.
- Rising edges are counted over a fixed window to expose a frequency select that uses the wrong tick.
- After a falling edge at duty 64, the bench writes duty 127 and expects the output to stay low until the wrap. A design that loads the duty at once would go high early.
- A reset in mid-run must leave every output low, even with the mode bit set afterwards.

// File: rtl/pwm_src_pkg.sv
package pwm_src_pkg;
  localparam int NUM_CH  = 11;
  localparam int NUM_GEN = 4;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 16;
  localparam int GEN_CH0 = 6;   // 0-based channel index served by generator 0

  localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
  localparam logic [ADDR_W-1:0] A_EN    = 3'd1;
  localparam logic [ADDR_W-1:0] A_FSEL  = 3'd2;
  localparam logic [ADDR_W-1:0] A_DUTY0 = 3'd4;

  typedef enum logic [1:0] {SRC_P1, SRC_P2, SRC_GEN} src_e;

  // Fixed routing map, channel index is 0-based
  function automatic src_e ch_src(input int ch, input logic mode);
    if (mode && ch >= GEN_CH0 && ch < GEN_CH0 + NUM_GEN) return SRC_GEN;
    if (ch == 4 || ch == 7 || ch == 9) return SRC_P2;
    return SRC_P1;
  endfunction

  function automatic int ch_gen(input int ch);
    if (ch >= GEN_CH0 && ch < GEN_CH0 + NUM_GEN) return ch - GEN_CH0;
    return 0;
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int DIV1 = 2,
  parameter int DIV2 = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic [1:0] tick_o
);
  localparam int DIVS [2] = '{DIV1, DIV2};

  for (genvar k = 0; k < 2; k++) begin : g_div
    localparam int DV = DIVS[k];
    if (DV < 2) begin : g_pass
      assign tick_o[k] = 1'b1;
    end else begin : g_cnt
      localparam int CW = $clog2(DV);
      logic [CW-1:0] cnt_q;
      logic          tick_q;
      always_ff @(posedge clk_i) begin
        if (rst_i) begin
          cnt_q  <= '0;
          tick_q <= 1'b0;
        end else if (cnt_q == CW'(DV - 1)) begin
          cnt_q  <= '0;
          tick_q <= 1'b1;
        end else begin
          cnt_q  <= cnt_q + 1'b1;
          tick_q <= 1'b0;
        end
      end
      assign tick_o[k] = tick_q;
    end
  end
endmodule

// File: rtl/pwm_duty_gen.sv
module pwm_duty_gen #(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [1:0]       tick_i,
  input  logic             fsel_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic             pwm_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] duty_act_q;
  logic             step;

  assign step = fsel_i ? tick_i[1] : tick_i[0];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q      <= '0;
      duty_act_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_MAX) duty_act_q <= duty_i;
    end
  end

  assign pwm_o = duty_act_q > cnt_q;
endmodule

// File: rtl/pwm_src_mux.sv
module pwm_src_mux
  import pwm_src_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               mode_i,
  input  logic [NUM_CH-1:0]  en_i,
  input  logic               pwm1_i,
  input  logic               pwm2_i,
  input  logic [NUM_GEN-1:0] gen_i,
  output logic [NUM_CH-1:0]  out_o
);
  logic [NUM_CH-1:0] sel;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam src_e S0 = ch_src(c, 1'b0);
    localparam src_e S1 = ch_src(c, 1'b1);
    localparam int   GI = ch_gen(c);
    always_comb begin
      case (mode_i ? S1 : S0)
        SRC_P1:  sel[c] = pwm1_i;
        SRC_P2:  sel[c] = pwm2_i;
        default: sel[c] = gen_i[GI];
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) out_o <= '0;
    else       out_o <= sel & en_i;
  end
endmodule

// File: rtl/pwm_src_gen.sv
module pwm_src_gen
  import pwm_src_pkg::*;
#(
  parameter int CNT_W = 7,
  parameter int DIV1  = 2,
  parameter int DIV2  = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [15:0]       wr_data_i,
  input  logic              pwm1_i,
  input  logic              pwm2_i,
  output logic [10:0]       out_en_o
);
  logic                 mode_q;
  logic [NUM_CH-1:0]    en_q;
  logic [NUM_GEN-1:0]   fsel_q;
  logic [CNT_W-1:0]     duty_q [NUM_GEN];
  logic [1:0]           tick;
  logic [NUM_GEN-1:0]   gen_pwm;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mode_q <= 1'b0;
      en_q   <= '0;
      fsel_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == A_MODE) mode_q <= wr_data_i[0];
      if (wr_addr_i == A_EN)   en_q   <= wr_data_i[NUM_CH-1:0];
      if (wr_addr_i == A_FSEL) fsel_q <= wr_data_i[NUM_GEN-1:0];
    end
  end

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    always_ff @(posedge clk_i) begin
      if (rst_i) duty_q[g] <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_W'(A_DUTY0 + g))
        duty_q[g] <= wr_data_i[CNT_W-1:0];
    end

    pwm_duty_gen #(.CNT_W(CNT_W)) gen_i (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .tick_i(tick),
      .fsel_i(fsel_q[g]),
      .duty_i(duty_q[g]),
      .pwm_o (gen_pwm[g])
    );
  end

  pwm_prescaler #(.DIV1(DIV1), .DIV2(DIV2)) presc_i (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .tick_o(tick)
  );

  pwm_src_mux mux_i (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .mode_i(mode_q),
    .en_i  (en_q),
    .pwm1_i(pwm1_i),
    .pwm2_i(pwm2_i),
    .gen_i (gen_pwm),
    .out_o (out_en_o)
  );
endmodule

// File: rtl/pwm_src_gen_chk.sv
module pwm_src_gen_chk (
  input logic        clk_i,
  input logic        rst_i,
  input logic        pwm1_i,
  input logic        pwm2_i,
  input logic        mode_q,
  input logic [10:0] en_q,
  input logic [3:0]  gen_pwm,
  input logic [10:0] out_en_o
);
  assert_reset_low_R8: assert property (@(posedge clk_i)
    rst_i |=> (out_en_o == '0));

  assert_gate_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_q[2] |=> !out_en_o[2]);

  assert_ch5_pwm2_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    en_q[4] |=> (out_en_o[4] == $past(pwm2_i)));

  assert_ch1_pwm1_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    en_q[0] |=> (out_en_o[0] == $past(pwm1_i)));

  assert_ch8_ext_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (!mode_q && en_q[7]) |=> (out_en_o[7] == $past(pwm2_i)));

  assert_ch9_gen_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_q && en_q[8]) |=> (out_en_o[8] == $past(gen_pwm[2])));
endmodule

bind pwm_src_gen pwm_src_gen_chk chk_i (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .pwm1_i  (pwm1_i),
  .pwm2_i  (pwm2_i),
  .mode_q  (mode_q),
  .en_q    (en_q),
  .gen_pwm (gen_pwm),
  .out_en_o(out_en_o)
);

// File: tb/pwm_src_gen_tb_top.sv
module pwm_src_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        p1 = 1'b0, p2 = 1'b0;
  logic [10:0] out_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwm_src_gen dut_i (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .pwm1_i(p1), .pwm2_i(p2), .out_en_o(out_en)
  );

  // {mode, enables[10:0], pwm1, pwm2, expected[10:0]}
  localparam logic [24:0] VEC [8] = '{
    {1'b0, 11'h7FF, 1'b1, 1'b0, 11'h56F},
    {1'b0, 11'h7FF, 1'b0, 1'b1, 11'h290},
    {1'b0, 11'h7FF, 1'b1, 1'b1, 11'h7FF},
    {1'b0, 11'h0AA, 1'b1, 1'b1, 11'h0AA},
    {1'b1, 11'h7FF, 1'b1, 1'b0, 11'h42F},
    {1'b1, 11'h7FF, 1'b0, 1'b1, 11'h010},
    {1'b1, 11'h7FF, 1'b1, 1'b1, 11'h43F},
    {1'b0, 11'h000, 1'b1, 1'b1, 11'h000}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measure(input int ch, input int n, output int highs, output int rises);
    logic prev;
    highs = 0; rises = 0;
    @(negedge clk);
    prev = out_en[ch];
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (out_en[ch]) highs++;
      if (out_en[ch] && !prev) rises++;
      prev = out_en[ch];
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    idle(3);
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog (all requirements): actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int h, r, h2, r2, h3, r3;
    p1 = 1'b1; p2 = 1'b1;
    idle(3);
    rst = 1'b0;
    idle(2);
    chk("R8 reset outputs low", out_en, 0);

    // table walk: R3 R4 R5 R6 routing and gating (duties still zero)
    for (int v = 0; v < 8; v++) begin
      wr(3'd0, {15'd0, VEC[v][24]});
      wr(3'd1, {5'd0, VEC[v][23:13]});
      p1 = VEC[v][12]; p2 = VEC[v][11];
      idle(3);
      chk($sformatf("R3/R4/R5/R6 vector %0d", v), out_en, VEC[v][10:0]);
    end

    // R9 latency: pin change visible one edge later
    wr(3'd0, 16'd0); wr(3'd1, 16'h7FF);
    p1 = 1'b0; p2 = 1'b0; idle(2);
    @(negedge clk) p1 = 1'b1;
    @(negedge clk);
    chk("R9 ch1 one edge after pin", out_en[0], 1);

    // R1 and R4: generator duties in mode 1, f1
    p1 = 1'b0; p2 = 1'b0;
    wr(3'd0, 16'd1); wr(3'd2, 16'd0);
    wr(3'd4, 16'd0); wr(3'd6, 16'd127); wr(3'd7, 16'd64);
    idle(600);
    fork
      measure(6, 256, h, r);
      measure(8, 256, h2, r2);
      measure(9, 256, h3, r3);
    join
    chk("R1 duty 0 constant low", h, 0);
    chk("R1 duty 127 high 127 of 128", h2, 254);
    chk("R1/R4 duty 64 on ch10", h3, 128);

    // R2: frequency select, ch8 at f2 and ch10 at f1
    wr(3'd5, 16'd32); wr(3'd2, 16'b0010);
    idle(1200);
    fork
      measure(7, 1024, h, r);
      measure(9, 1024, h2, r2);
    join
    chk("R2 f2 period rises", r, 2);
    chk("R2 f2 duty 32 highs", h, 256);
    chk("R2 f1 period rises", r2, 4);

    // R6: gated generator stays low
    wr(3'd1, 16'h7FF & ~16'h100);
    measure(8, 300, h, r);
    chk("R6 disabled ch9 with duty 127", h, 0);
    wr(3'd1, 16'h7FF);

    // R7: duty change applies only at wrap (ch10, duty 64, f1)
    @(negedge clk);
    while (out_en[9] !== 1'b1) @(negedge clk);
    while (out_en[9] !== 1'b0) @(negedge clk);
    wr(3'd7, 16'd127);
    measure(9, 100, h, r);
    chk("R7 no early load after write", h, 0);
    idle(40);
    chk("R7 new duty after wrap", out_en[9], 1);

    // R8: reset in mid-run clears duties and mode
    do_reset();
    p1 = 1'b0; p2 = 1'b1;
    wr(3'd1, 16'h7FF);
    idle(2);
    chk("R8 mode cleared by reset", out_en, 11'h290);
    p2 = 1'b0;
    wr(3'd0, 16'd1);
    measure(8, 600, h, r);
    chk("R8 duty cleared by reset", h, 0);
    chk("R8 all outputs low", out_en, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule